// File: doc/BRIEF.md
# ADC Capture-to-Memory Sequencer

This block moves converter results into external data memory on its own, so that the processor does not have to service every sample. Software first prepares a table in external memory: each two-byte slot holds, in the top nibble of its first byte, the number of the analog channel to sample there. Software then loads a 24-bit start pointer through three byte-wide configuration selects and sets the run bit. The sequencer reads each slot's channel number, asks the converter for a sample on that channel and overwrites the slot with the result. The first byte receives the channel number and the top four result bits. The second byte receives the low eight result bits. The pointer then advances to the next slot. A slot whose channel number is 0xF ends the run and raises a completion flag.

The state machine has five states. IDLE holds the bus for the processor. FETCH reads the channel byte at the pointer. CONV holds the conversion request until the converter answers. WR_HI writes the first result byte. WR_LO writes the second result byte and advances the pointer. The transitions are: IDLE to FETCH when the run bit is set and the converter configuration is valid; FETCH to CONV on an ordinary channel; FETCH to IDLE, setting the flag, on the terminator (finish); FETCH to IDLE, without the flag, when the run bit has been cleared (abort); CONV to WR_HI on converter done; WR_HI to WR_LO; and WR_LO to FETCH. Outside IDLE the sequencer owns the external address, data and strobe pins. Processor accesses in that time are discarded.

Top module: `adc_dma_capture`

## Requirements
- R1: After reset the sequencer is idle, the completion flag is 0, the run bit is 0, the pointer is 0 and no memory or conversion strobe is driven by the sequencer.
- R2: Configuration select 0 loads pointer bits 7:0, select 1 loads bits 15:8 and select 2 loads bits 23:16. Pointer writes are ignored while a capture is active (busy high).
- R3: Select 3 is the control byte, and its bit 6 is the run bit. A capture starts, with busy rising, only while the run bit is 1 and `conv_cfg_ok` is high. With `conv_cfg_ok` low the block stays idle.
- R4: In each slot the sequencer issues one read at the pointer and takes bits 7:4 of the returned byte as the channel. It then holds `adc_req` high with that channel on `adc_chan`, stable, until the cycle in which `adc_done` is high.
- R5: After `adc_done`, two consecutive write cycles follow. The first writes `{channel, result[11:8]}` at the pointer. The second writes `result[7:0]` at pointer+1. The next slot's read is at pointer+2.
- R6: A slot whose channel bits are 0xF requests no conversion. It sets the completion flag, clears the run bit and returns to idle, and the pointer stays at the terminator slot.
- R7: Clearing the run bit during a capture lets the current slot finish. The run then stops at the next slot read, with no conversion, no write and no completion flag.
- R8: A write to select 3 with bit 7 = 0 clears the completion flag, and bit 7 = 1 leaves it unchanged. A flag set by a terminator in the same cycle takes precedence over both the software clear and the run-bit write.
- R9: While busy, processor read and write strobes never reach `mem_rd`/`mem_wr`, and address and data pins carry the sequencer's values. While idle, the processor's strobes, address and data pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration select: 0..2 pointer bytes, 3 control |
| cfg_wdata | input | 8 | Configuration write data |
| conv_cfg_ok | input | 1 | Converter timing and trigger setup is valid |
| adc_req | output | 1 | Conversion request, held until done |
| adc_chan | output | 4 | Channel for the requested conversion |
| adc_done | input | 1 | Conversion finished, result valid this cycle |
| adc_result | input | 12 | Straight-binary conversion result |
| cpu_rd | input | 1 | Processor read strobe toward the external bus |
| cpu_wr | input | 1 | Processor write strobe toward the external bus |
| cpu_addr | input | 24 | Processor external address |
| cpu_wdata | input | 8 | Processor write data |
| mem_rd | output | 1 | External memory read strobe |
| mem_wr | output | 1 | External memory write strobe |
| mem_addr | output | 24 | External memory byte address |
| mem_wdata | output | 8 | External memory write data |
| mem_rdata | input | 8 | External memory read data, valid in the read cycle |
| dma_busy | output | 1 | Capture active, sequencer owns the bus |
| irq_flag | output | 1 | Completion flag |

## Verification
Two events can fall in the same cycle: the terminator slot finishing a run, and a software control write that clears both the completion flag and the run bit. The bench waits until the pins show the read of the known terminator address, and it drives the control write in exactly that cycle. It then expects the flag to be 1 and the block idle, because the hardware set wins and the run bit was still 1 when the slot was judged. A behavioural model that runs alongside the design makes the same prediction on every clock. The bench also checks an abort raised during a conversion against the untouched contents of the next slot.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_CONV  = 3'd2,
        ST_WR_HI = 3'd3,
        ST_WR_LO = 3'd4
    } dma_state_e;

    // Bit positions inside the control byte
    localparam int CTRL_EN_BIT   = 6;
    localparam int CTRL_FLAG_BIT = 7;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import adc_dma_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [SW-1:0] cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          busy,
    input  logic          ptr_inc,
    input  logic          fin_set,
    output logic [AW-1:0] ptr,
    output logic          en,
    output logic          flag
);

    localparam int            NB       = AW / DW;
    localparam logic [SW-1:0] CTRL_SEL = SW'(NB);

    logic [AW-1:0] ptr_sum;
    logic          ctrl_wr;

    assign ptr_sum = ptr + AW'(2);
    assign ctrl_wr = cfg_wr && (cfg_sel == CTRL_SEL);

    // One byte register per pointer byte; loads only while idle (R2)
    for (genvar b = 0; b < NB; b++) begin : g_ptr_byte
        logic [DW-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (ptr_inc) begin
                byte_q <= ptr_sum[b*DW +: DW];
            end else if (cfg_wr && !busy && (cfg_sel == SW'(b))) begin
                byte_q <= cfg_wdata;
            end
        end
        assign ptr[b*DW +: DW] = byte_q;
    end

    // Run bit and completion flag; the terminator has precedence (R6, R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en   <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (fin_set) begin
                en <= 1'b0;
            end else if (ctrl_wr) begin
                en <= cfg_wdata[CTRL_EN_BIT];
            end
            if (fin_set) begin
                flag <= 1'b1;
            end else if (ctrl_wr) begin
                flag <= flag & cfg_wdata[CTRL_FLAG_BIT];
            end
        end
    end

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !ptr_inc |=> $stable(ptr)); // R2

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(fin_set)); // R6

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import adc_dma_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 8,
    parameter int RW = 12,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cfg_ok,
    input  logic [AW-1:0] ptr,
    input  logic [DW-1:0] rd_data,
    input  logic          adc_done,
    input  logic [RW-1:0] adc_result,
    output logic          busy,
    output logic          dma_rd,
    output logic          dma_wr,
    output logic          wr_lo,
    output logic [AW-1:0] dma_addr,
    output logic [DW-1:0] dma_wdata,
    output logic          adc_req,
    output logic [CW-1:0] adc_chan,
    output logic          ptr_inc,
    output logic          fin_set
);

    localparam int HI_W = DW - CW;

    dma_state_e    state_q, state_d;
    logic [CW-1:0] chan_q;
    logic [RW-1:0] res_q;
    logic [CW-1:0] slot_id;
    logic          slot_term;
    logic [HI_W-1:0] slot_low_unused;

    assign slot_id         = rd_data[DW-1 -: CW];
    assign slot_low_unused = rd_data[HI_W-1:0];
    assign slot_term       = (slot_id == {CW{1'b1}});

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en && cfg_ok) state_d = ST_FETCH;
            ST_FETCH: begin
                if (!en)            state_d = ST_IDLE;   // abort
                else if (slot_term) state_d = ST_IDLE;   // finish
                else                state_d = ST_CONV;
            end
            ST_CONV:  if (adc_done) state_d = ST_WR_HI;
            ST_WR_HI: state_d = ST_WR_LO;
            ST_WR_LO: state_d = ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Slot datapath: channel from the fetched byte, result from the converter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            res_q  <= '0;
        end else begin
            if (state_q == ST_FETCH) chan_q <= slot_id;
            if (state_q == ST_CONV && adc_done) res_q <= adc_result;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        dma_rd    = 1'b0;
        dma_wr    = 1'b0;
        wr_lo     = 1'b0;
        adc_req   = 1'b0;
        ptr_inc   = 1'b0;
        fin_set   = 1'b0;
        dma_addr  = ptr;
        dma_wdata = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: begin
                dma_rd  = 1'b1;
                fin_set = en && slot_term;
            end
            ST_CONV:  adc_req = 1'b1;
            ST_WR_HI: begin
                dma_wr    = 1'b1;
                dma_wdata = {chan_q, res_q[RW-1 -: HI_W]};
            end
            ST_WR_LO: begin
                dma_wr    = 1'b1;
                wr_lo     = 1'b1;
                ptr_inc   = 1'b1;
                dma_addr  = ptr + AW'(1);
                dma_wdata = res_q[DW-1:0];
            end
            default:  ;
        endcase
    end

    assign adc_chan = chan_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req && !adc_done |=> adc_req); // R4

    AST_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req |=> $stable(adc_chan)); // R4

endmodule

// File: rtl/dma_bus_mux.sv
module dma_bus_mux #(
    parameter int AW = 24,
    parameter int DW = 8
) (
    input  logic          busy,
    input  logic          dma_rd,
    input  logic          dma_wr,
    input  logic [AW-1:0] dma_addr,
    input  logic [DW-1:0] dma_wdata,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    // Processor strobes are dropped while the sequencer owns the pins (R9)
    always_comb begin
        if (busy) begin
            mem_rd    = dma_rd;
            mem_wr    = dma_wr;
            mem_addr  = dma_addr;
            mem_wdata = dma_wdata;
        end else begin
            mem_rd    = cpu_rd;
            mem_wr    = cpu_wr;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end
    end

endmodule

// File: rtl/adc_dma_capture.sv
module adc_dma_capture #(
    parameter int ADDR_W = 24,
    parameter int BYTE_W = 8,
    parameter int RES_W  = 12,
    parameter int CH_W   = 4,
    localparam int NBYTES = ADDR_W / BYTE_W,
    localparam int SEL_W  = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              conv_cfg_ok,
    output logic              adc_req,
    output logic [CH_W-1:0]   adc_chan,
    input  logic              adc_done,
    input  logic [RES_W-1:0]  adc_result,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              dma_busy,
    output logic              irq_flag
);

    logic [ADDR_W-1:0] ptr;
    logic              run_en;
    logic              ptr_inc;
    logic              fin_set;
    logic              dma_rd;
    logic              dma_wr;
    logic              dma_wr_lo;
    logic [ADDR_W-1:0] dma_addr;
    logic [BYTE_W-1:0] dma_wdata;

    dma_cfg_regs #(
        .AW(ADDR_W), .DW(BYTE_W), .SW(SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .busy      (dma_busy),
        .ptr_inc   (ptr_inc),
        .fin_set   (fin_set),
        .ptr       (ptr),
        .en        (run_en),
        .flag      (irq_flag)
    );

    dma_seq #(
        .AW(ADDR_W), .DW(BYTE_W), .RW(RES_W), .CW(CH_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (run_en),
        .cfg_ok     (conv_cfg_ok),
        .ptr        (ptr),
        .rd_data    (mem_rdata),
        .adc_done   (adc_done),
        .adc_result (adc_result),
        .busy       (dma_busy),
        .dma_rd     (dma_rd),
        .dma_wr     (dma_wr),
        .wr_lo      (dma_wr_lo),
        .dma_addr   (dma_addr),
        .dma_wdata  (dma_wdata),
        .adc_req    (adc_req),
        .adc_chan   (adc_chan),
        .ptr_inc    (ptr_inc),
        .fin_set    (fin_set)
    );

    dma_bus_mux #(
        .AW(ADDR_W), .DW(BYTE_W)
    ) u_mux (
        .busy      (dma_busy),
        .dma_rd    (dma_rd),
        .dma_wr    (dma_wr),
        .dma_addr  (dma_addr),
        .dma_wdata (dma_wdata),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    AST_LO_FOLLOWS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr_lo |-> mem_addr == $past(mem_addr) + ADDR_W'(1)); // R5

    AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> (mem_wr == dma_wr) && (mem_rd == dma_rd)); // R9

endmodule

// File: tb/test_adc_dma_capture.sv
module test_adc_dma_capture;

    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic        conv_cfg_ok = 1'b0;
    logic        adc_req;
    logic [3:0]  adc_chan;
    logic        adc_done = 1'b0;
    logic [11:0] adc_result = 12'd0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [23:0] cpu_addr = 24'd0;
    logic [7:0]  cpu_wdata = 8'd0;
    logic        mem_rd;
    logic        mem_wr;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        dma_busy;
    logic        irq_flag;

    always #(TCK/2) clk = ~clk;

    adc_dma_capture i_adc_dma_capture (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .conv_cfg_ok(conv_cfg_ok),
        .adc_req(adc_req), .adc_chan(adc_chan), .adc_done(adc_done),
        .adc_result(adc_result), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dma_busy(dma_busy), .irq_flag(irq_flag)
    );

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // External memory (low 9 address bits decoded)
    logic [7:0] xmem [0:511];
    assign mem_rdata = xmem[mem_addr[8:0]];

    // Converter environment: answers after adc_lat cycles of request
    int          adc_lat = 2;
    int          adc_cnt = 0;
    logic [11:0] res_seed = 12'h123;
    logic [15:0] issued [$];

    always @(negedge clk) begin
        if (adc_req) begin
            if (adc_cnt == adc_lat) begin
                logic [11:0] v;
                v = 12'(adc_chan) * 12'd257 + res_seed;
                res_seed = res_seed + 12'd101;
                adc_done   <= 1'b1;
                adc_result <= v;
                issued.push_back({adc_chan, v});
                adc_cnt = 0;
            end else begin
                adc_done <= 1'b0;
                adc_cnt  = adc_cnt + 1;
            end
        end else begin
            adc_done <= 1'b0;
            adc_cnt  = 0;
        end
    end

    // Behavioural reference: phase 0 idle, 1 read, 2 convert, 3/4 write bytes
    int          m_ph;
    logic [23:0] m_ptr;
    logic        m_en, m_flag;
    logic [3:0]  m_chan, m_id;
    logic [11:0] m_res;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_ptr = '0; m_en = 0; m_flag = 0; m_chan = '0; m_res = '0;
        end else begin
            int          ph_n;
            logic [23:0] ptr_n;
            logic        en_n, fl_n;
            ph_n = m_ph; ptr_n = m_ptr; en_n = m_en; fl_n = m_flag;
            if (cfg_wr && m_ph == 0) begin
                if (cfg_sel == 2'd0) ptr_n[7:0]   = cfg_wdata;
                if (cfg_sel == 2'd1) ptr_n[15:8]  = cfg_wdata;
                if (cfg_sel == 2'd2) ptr_n[23:16] = cfg_wdata;
            end
            if (cfg_wr && cfg_sel == 2'd3) begin
                en_n = cfg_wdata[6];
                fl_n = m_flag & cfg_wdata[7];
            end
            case (m_ph)
                0: if (m_en && conv_cfg_ok) ph_n = 1;
                1: begin
                    m_id = xmem[m_ptr[8:0]][7:4];
                    m_chan = m_id;
                    if (!m_en) ph_n = 0;
                    else if (m_id == 4'hF) begin ph_n = 0; en_n = 0; fl_n = 1; end
                    else ph_n = 2;
                end
                2: if (adc_done) begin m_res = adc_result; ph_n = 3; end
                3: ph_n = 4;
                default: begin ptr_n = m_ptr + 24'd2; ph_n = 1; end
            endcase
            m_ph = ph_n; m_ptr = ptr_n; m_en = en_n; m_flag = fl_n;
        end
        if (mem_wr) xmem[mem_addr[8:0]] <= mem_wdata;
    end

    // Per-cycle comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(TCK/4);
        if (rst_n) begin
            logic        e_rd, e_wr;
            logic [23:0] e_addr;
            logic [7:0]  e_wd;
            string       bt;
            e_rd   = (m_ph == 1) || (m_ph == 0 && cpu_rd);
            e_wr   = (m_ph == 3) || (m_ph == 4) || (m_ph == 0 && cpu_wr);
            e_addr = (m_ph == 0) ? cpu_addr : ((m_ph == 4) ? m_ptr + 24'd1 : m_ptr);
            e_wd   = (m_ph == 0) ? cpu_wdata :
                     ((m_ph == 3) ? {m_chan, m_res[11:8]} : m_res[7:0]);
            bt     = (m_ph == 0) ? "R9" : ((m_ph >= 3) ? "R5" : "R4");
            chk("R3", "busy", 32'(dma_busy), 32'(m_ph != 0));
            chk("R6", "irq_flag", 32'(irq_flag), 32'(m_flag));
            chk("R4", "adc_req", 32'(adc_req), 32'(m_ph == 2));
            if (m_ph == 2) chk("R4", "adc_chan", 32'(adc_chan), 32'(m_chan));
            chk(bt, "mem_rd", 32'(mem_rd), 32'(e_rd));
            chk(bt, "mem_wr", 32'(mem_wr), 32'(e_wr));
            chk(bt, "mem_addr", 32'(mem_addr), 32'(e_addr));
            if (e_wr) chk(bt, "mem_wdata", 32'(mem_wdata), 32'(e_wd));
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    logic [3:0] ids [$];

    task automatic cfg(input logic [1:0] s, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_ptr(input logic [23:0] p);
        cfg(2'd0, p[7:0]); cfg(2'd1, p[15:8]); cfg(2'd2, p[23:16]);
    endtask

    task automatic fill(input int base);
        for (int i = 0; i < ids.size(); i++) begin
            xmem[base + 2*i]     <= {ids[i], 4'h0};
            xmem[base + 2*i + 1] <= 8'h00;
        end
        @(negedge clk);
    endtask

    task automatic run_to_idle();
        int n = 0;
        while (!dma_busy && n < 20) begin @(negedge clk); n++; end
        while (dma_busy) @(negedge clk);
    endtask

    task automatic check_slots(input string tag, input int base, input int n);
        for (int i = 0; i < n; i++) begin
            logic [15:0] w;
            w = (i < issued.size()) ? issued[i] : 16'hxxxx;
            chk("R4", "requested channel", 32'(w[15:12]), 32'(ids[i]));
            chk(tag, "result high byte", 32'(xmem[base + 2*i]), 32'({ids[i], w[11:8]}));
            chk(tag, "result low byte", 32'(xmem[base + 2*i + 1]), 32'(w[7:0]));
        end
    endtask

    initial begin
        for (int i = 0; i < 512; i++) xmem[i] <= 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", 32'(dma_busy), 32'd0);
        chk("R1", "flag in reset", 32'(irq_flag), 32'd0);
        chk("R1", "mem_rd in reset", 32'(mem_rd), 32'd0);
        chk("R1", "mem_wr in reset", 32'(mem_wr), 32'd0);
        chk("R1", "adc_req in reset", 32'(adc_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Run A: page-high pointer, terminator after three slots
        ids = '{4'h3, 4'h7, 4'h0, 4'hF};
        fill(9'h010);
        load_ptr(24'h5A0010);
        cfg(2'd3, 8'h40);
        repeat (8) @(negedge clk);
        chk("R3", "idle without converter setup", 32'(dma_busy), 32'd0);
        cpu_wr = 1'b1; cpu_addr = 24'h000100; cpu_wdata = 8'hA5;
        @(negedge clk);
        cpu_wr = 1'b0;
        chk("R9", "idle processor write reaches memory", 32'(xmem[9'h100]), 32'hA5);
        issued.delete();
        adc_lat = 2;
        conv_cfg_ok = 1'b1;
        run_to_idle();
        chk("R6", "flag after terminator", 32'(irq_flag), 32'd1);
        chk("R6", "conversions before terminator", 32'(issued.size()), 32'd3);
        chk("R6", "terminator slot kept", 32'(xmem[9'h016]), 32'hF0);
        check_slots("R5", 9'h010, 3);
        repeat (5) @(negedge clk);
        chk("R6", "run bit cleared at finish", 32'(dma_busy), 32'd0);
        // Restart without reloading: pointer still at the terminator
        cfg(2'd3, 8'h40);
        chk("R8", "flag cleared by control write", 32'(irq_flag), 32'd0);
        run_to_idle();
        chk("R6", "restart ends at terminator", 32'(irq_flag), 32'd1);
        chk("R6", "no conversion on restart", 32'(issued.size()), 32'd3);

        // Run B: abort mid-capture, ignored pointer write, gated processor write
        ids = '{4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'hF};
        fill(9'h080);
        load_ptr(24'h000080);
        issued.delete();
        adc_lat = 6;
        cfg(2'd3, 8'h40);
        while (!adc_req) @(negedge clk);
        cfg(2'd0, 8'hEE);
        cpu_wr = 1'b1; cpu_addr = 24'h0001F0; cpu_wdata = 8'h3C;
        @(negedge clk);
        cpu_wr = 1'b0;
        chk("R9", "processor write blocked while busy", 32'(xmem[9'h1F0]), 32'h00);
        while (!(issued.size() == 1 && adc_req)) @(negedge clk);
        cfg(2'd3, 8'h00);
        run_to_idle();
        chk("R7", "no flag after abort", 32'(irq_flag), 32'd0);
        chk("R7", "conversions before abort", 32'(issued.size()), 32'd2);
        chk("R7", "slot after abort untouched", 32'(xmem[9'h084]), 32'h40);
        check_slots("R2", 9'h080, 2);

        // Run C: terminator read collides with a clearing control write
        ids = '{4'h9, 4'hF};
        fill(9'h0C0);
        load_ptr(24'h0000C0);
        issued.delete();
        adc_lat = 2;
        cfg(2'd3, 8'h40);
        while (!(dma_busy && mem_rd && mem_addr == 24'h0000C2)) @(negedge clk);
        cfg(2'd3, 8'h00);
        chk("R8", "terminator set wins over clear", 32'(irq_flag), 32'd1);
        chk("R8", "idle after collision", 32'(dma_busy), 32'd0);
        check_slots("R5", 9'h0C0, 1);
        cfg(2'd3, 8'h80);
        chk("R8", "bit7 one keeps flag", 32'(irq_flag), 32'd1);
        cfg(2'd3, 8'h00);
        chk("R8", "bit7 zero clears flag", 32'(irq_flag), 32'd0);

        // Run D: fifteen channels back to back, short latency
        ids.delete();
        for (int i = 0; i < 15; i++) ids.push_back(4'(i));
        ids.push_back(4'hF);
        fill(9'h140);
        load_ptr(24'hFF0140);
        issued.delete();
        adc_lat = 1;
        cfg(2'd3, 8'h40);
        run_to_idle();
        chk("R6", "flag after long run", 32'(irq_flag), 32'd1);
        chk("R6", "long run conversions", 32'(issued.size()), 32'd15);
        check_slots("R5", 9'h140, 15);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule